// File: doc/BRIEF.md
# Coherent Snapshot Register File for a Calendar Clock

This block is the byte-wide register file that sits between a serial host bus and a running calendar counter. It holds twenty bytes at addresses 00h to 13h. The lowest eight are user copies of the clock bytes. The other twelve are plain storage for alarm, control, square-wave and oscillator-output settings. The bus side presents an already decoded byte stream: a pointer load, read strobes, write strobes and a stop event. The counter side presents its internal time bytes and a tick that marks each time they have advanced.

On every tick the user copies of all eight clock bytes are refreshed together in one cycle. When the host reads a clock byte, further refreshes are held off. This keeps a burst read over several clock bytes coherent: no carry can land between two bytes of the same read. The hold ends when the host issues a stop, or when the pointer moves to a non-clock address. Any tick that arrived during the hold is replayed as a single refresh right after the hold ends. A write to a clock byte updates the user copy and is passed on to the counter as a load. The counter uses that load to set its time and to reset its divider chain.

The pointer advances by one after every read or write byte and wraps from the last address back to 00h. Bytes are stored exactly as written, whether the host uses them as BCD or as binary.

Top module: `rtcx_regfile`

## Requirements
- R1: After reset, every one of the 20 bytes reads as 00h, the pointer is 00h, `rd_data` is 00h and `cnt_load` is low.
- R2: A pointer load sets the pointer to `addr_in`. A value of 20 or more sets it to 00h. The pointer never leaves 00h..13h.
- R3: A read strobe puts the byte at the pointer onto `rd_data` after the next clock edge and advances the pointer by one. From 13h the pointer wraps to 00h.
- R4: A write strobe stores `wr_data` unchanged at the pointer and advances the pointer with the same wrap. A later read returns exactly that byte.
- R5: Outside a hold, a `cnt_tick` copies all eight bytes of `cnt_time` into clock bytes 00h..07h at the same edge. Byte k is taken from bits 8k+7..8k.
- R6: A read strobe at a clock address starts a hold. This includes the strobe cycle itself, so a tick in that cycle cannot change the bytes still to be read. While the hold lasts, the clock bytes do not change except by host writes.
- R7: A hold ends on `bus_stop`, or when the pointer lands on 08h..13h, whether by auto-increment or by a pointer load.
- R8: Ticks that arrive during a hold produce exactly one refresh, one cycle after the hold ends. That refresh takes the `cnt_time` value present at that moment. Later changes of `cnt_time` without a tick change nothing.
- R9: A write to clock address k raises `cnt_load` for one cycle after the edge, with `cnt_load_idx` = k and `cnt_load_byte` = the written byte. Writes to 08h..13h leave `cnt_load` low.
- R10: Reads of 08h..13h never start a hold, even when the pointer then wraps into the clock range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_stop | input | 1 | Stop event from the host bus, one cycle |
| addr_load | input | 1 | Load the pointer from `addr_in` |
| addr_in | input | 5 | Byte address to load |
| rd_stb | input | 1 | Read one byte at the pointer |
| wr_stb | input | 1 | Write `wr_data` at the pointer |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Byte captured by the last read strobe |
| cnt_tick | input | 1 | Counter internal copy has advanced |
| cnt_time | input | 64 | Counter internal copy, byte k in bits 8k+7..8k |
| cnt_load | output | 1 | Host wrote a clock byte, one-cycle pulse |
| cnt_load_idx | output | 3 | Index of the written clock byte |
| cnt_load_byte | output | 8 | Value written to that clock byte |

## Verification
The bench goes after several corner cases. One is a tick that falls in the very cycle of the first clock-byte read. A design that gates refreshes only from the next cycle would return a torn time across the burst. Another is a burst spanning several ticks: a design that drops a pending refresh would keep stale time after release, and one that replays a stale value would show the middle tick's value. The bench also releases the hold by stop and by a pointer load into the upper range; a design that misses either release would freeze the clock bytes for good. Finally, it reads address 13h so that the pointer wraps into the clock range. A design that starts a hold on any read would never refresh afterwards.

// File: rtl/rtcx_pkg.sv
package rtcx_pkg;
  localparam int unsigned RTCX_NREG = 20;
  localparam int unsigned RTCX_NCLK = 8;
  localparam int unsigned RTCX_DW   = 8;
endpackage

// File: rtl/rtcx_rst_sync.sv
module rtcx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/rtcx_ptr_ctl.sv
// Pointer, strobe qualification and the read hold.
module rtcx_ptr_ctl #(
  parameter int unsigned NREG = 20,
  parameter int unsigned NCLK = 8,
  parameter int unsigned AW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_stop,
  input  logic          addr_load,
  input  logic [AW-1:0] addr_in,
  input  logic          rd_stb,
  input  logic          wr_stb,
  output logic [AW-1:0] ptr_q,
  output logic          hold_q,
  output logic          rd_act,
  output logic          wr_act,
  output logic          rd_clk
);
  localparam logic [AW-1:0] LAST = AW'(NREG - 1);

  logic [AW-1:0] ptr_nx;
  logic          hold_nx;
  logic          ptr_en;

  always_comb begin
    rd_act = rd_stb & ~addr_load;
    wr_act = wr_stb & ~addr_load & ~rd_stb;
    rd_clk = rd_act & (int'(ptr_q) < int'(NCLK));
    ptr_en = addr_load | rd_act | wr_act;

    if (addr_load)
      ptr_nx = (int'(addr_in) < int'(NREG)) ? addr_in : '0;
    else if (ptr_q == LAST)
      ptr_nx = '0;
    else
      ptr_nx = ptr_q + 1'b1;

    if (bus_stop)
      hold_nx = 1'b0;
    else if (ptr_en && int'(ptr_nx) >= int'(NCLK))
      hold_nx = 1'b0;
    else if (rd_clk)
      hold_nx = 1'b1;
    else
      hold_nx = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      if (ptr_en) ptr_q <= ptr_nx;
      hold_q <= hold_nx;
    end
  end
endmodule

// File: rtl/rtcx_xfer_gate.sv
// Decides when the internal copy is transferred; remembers held ticks.
module rtcx_xfer_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic block,
  output logic xfer,
  output logic pend_q
);
  logic want;
  logic pend_nx;

  always_comb begin
    want    = tick | pend_q;
    xfer    = want & ~block;
    pend_nx = want & block;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_nx;
  end
endmodule

// File: rtl/rtcx_store.sv
// Byte array (user clock copies plus plain bytes), read capture, load pulse.
module rtcx_store #(
  parameter int unsigned NREG = 20,
  parameter int unsigned NCLK = 8,
  parameter int unsigned DW   = 8,
  parameter int unsigned AW   = 5,
  parameter int unsigned CW   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      ptr_q,
  input  logic               rd_act,
  input  logic               wr_act,
  input  logic [DW-1:0]      wr_data,
  input  logic               xfer,
  input  logic [NCLK*DW-1:0] cnt_time,
  output logic [DW-1:0]      rd_data,
  output logic [NCLK*DW-1:0] user_clk,
  output logic               ld_q,
  output logic [CW-1:0]      ld_idx_q,
  output logic [DW-1:0]      ld_byte_q
);
  logic [DW-1:0] mem_q  [NREG];
  logic [DW-1:0] mem_nx [NREG];
  logic [DW-1:0] rd_nx;
  logic          ld_nx;

  genvar g;
  generate
    for (g = 0; g < int'(NREG); g++) begin : g_byte
      logic hit;
      always_comb begin
        hit = wr_act && (int'(ptr_q) == g);
        if (hit)
          mem_nx[g] = wr_data;
        else if (g < int'(NCLK) && xfer)
          mem_nx[g] = cnt_time[(g % int'(NCLK))*DW +: DW];
        else
          mem_nx[g] = mem_q[g];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q[g] <= '0;
        else        mem_q[g] <= mem_nx[g];
      end
    end

    for (g = 0; g < int'(NCLK); g++) begin : g_view
      assign user_clk[g*DW +: DW] = mem_q[g];
    end
  endgenerate

  always_comb begin
    rd_nx = '0;
    for (int i = 0; i < int'(NREG); i++)
      if (int'(ptr_q) == i) rd_nx = mem_q[i];
    ld_nx = wr_act & (int'(ptr_q) < int'(NCLK));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data   <= '0;
      ld_q      <= 1'b0;
      ld_idx_q  <= '0;
      ld_byte_q <= '0;
    end else begin
      if (rd_act) rd_data <= rd_nx;
      ld_q <= ld_nx;
      if (ld_nx) begin
        ld_idx_q  <= CW'(ptr_q);
        ld_byte_q <= wr_data;
      end
    end
  end
endmodule

// File: rtl/rtcx_regfile.sv
module rtcx_regfile #(
  parameter int unsigned NREG = rtcx_pkg::RTCX_NREG,
  parameter int unsigned NCLK = rtcx_pkg::RTCX_NCLK,
  parameter int unsigned DW   = rtcx_pkg::RTCX_DW,
  localparam int unsigned AW  = $clog2(NREG),
  localparam int unsigned CW  = (NCLK > 1) ? $clog2(NCLK) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_stop,
  input  logic               addr_load,
  input  logic [AW-1:0]      addr_in,
  input  logic               rd_stb,
  input  logic               wr_stb,
  input  logic [DW-1:0]      wr_data,
  output logic [DW-1:0]      rd_data,
  input  logic               cnt_tick,
  input  logic [NCLK*DW-1:0] cnt_time,
  output logic               cnt_load,
  output logic [CW-1:0]      cnt_load_idx,
  output logic [DW-1:0]      cnt_load_byte
);
  logic          rst_s_n;
  logic [AW-1:0] ptr_q;
  logic          hold_q;
  logic          rd_act;
  logic          wr_act;
  logic          rd_clk;
  logic          xfer;
  logic          pend_q;
  logic          block;
  logic [NCLK*DW-1:0] user_clk;

  rtcx_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  rtcx_ptr_ctl #(.NREG(NREG), .NCLK(NCLK), .AW(AW)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .bus_stop  (bus_stop),
    .addr_load (addr_load),
    .addr_in   (addr_in),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .ptr_q     (ptr_q),
    .hold_q    (hold_q),
    .rd_act    (rd_act),
    .wr_act    (wr_act),
    .rd_clk    (rd_clk)
  );

  assign block = hold_q | rd_clk;

  rtcx_xfer_gate u_xfer (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .tick   (cnt_tick),
    .block  (block),
    .xfer   (xfer),
    .pend_q (pend_q)
  );

  rtcx_store #(.NREG(NREG), .NCLK(NCLK), .DW(DW), .AW(AW), .CW(CW)) u_store (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .ptr_q     (ptr_q),
    .rd_act    (rd_act),
    .wr_act    (wr_act),
    .wr_data   (wr_data),
    .xfer      (xfer),
    .cnt_time  (cnt_time),
    .rd_data   (rd_data),
    .user_clk  (user_clk),
    .ld_q      (cnt_load),
    .ld_idx_q  (cnt_load_idx),
    .ld_byte_q (cnt_load_byte)
  );
endmodule

// File: rtl/rtcx_regfile_chk.sv
module rtcx_regfile_chk #(
  parameter int unsigned NREG = 20,
  parameter int unsigned NCLK = 8,
  parameter int unsigned DW   = 8,
  parameter int unsigned AW   = 5
) (
  input logic               clk,
  input logic               rst_s_n,
  input logic               bus_stop,
  input logic               addr_load,
  input logic               rd_stb,
  input logic               wr_stb,
  input logic [AW-1:0]      ptr_q,
  input logic               hold_q,
  input logic               pend_q,
  input logic [NCLK*DW-1:0] user_clk,
  input logic               cnt_load
);
  logic ptr_in_clk;
  assign ptr_in_clk = int'(ptr_q) < int'(NCLK);

  p_ptr_range_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    int'(ptr_q) < int'(NREG));

  p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (hold_q && !wr_stb) |=> $stable(user_clk));

  p_stop_release_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    bus_stop |=> !hold_q);

  p_single_replay_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pend_q && !hold_q && !(rd_stb && !addr_load && ptr_in_clk)) |=> !pend_q);

  p_load_pulse_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_stb && !rd_stb && !addr_load && ptr_in_clk) |=> cnt_load);

  p_nonclk_read_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_stb && !addr_load && !ptr_in_clk && !hold_q) |=> !hold_q);
endmodule

bind rtcx_regfile rtcx_regfile_chk #(.NREG(NREG), .NCLK(NCLK), .DW(DW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_s_n  (rst_s_n),
  .bus_stop (bus_stop),
  .addr_load(addr_load),
  .rd_stb   (rd_stb),
  .wr_stb   (wr_stb),
  .ptr_q    (ptr_q),
  .hold_q   (hold_q),
  .pend_q   (pend_q),
  .user_clk (user_clk),
  .cnt_load (cnt_load)
);

// File: tb/sim_rtcx_regfile.sv
module sim_rtcx_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_stop = 1'b0, addr_load = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
  logic [4:0]  addr_in = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        cnt_tick = 1'b0;
  logic [63:0] cnt_time = '0;
  logic        cnt_load;
  logic [2:0]  cnt_load_idx;
  logic [7:0]  cnt_load_byte;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtcx_regfile u0 (
    .clk(clk), .rst_n(rst_n), .bus_stop(bus_stop), .addr_load(addr_load),
    .addr_in(addr_in), .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_data(rd_data), .cnt_tick(cnt_tick), .cnt_time(cnt_time),
    .cnt_load(cnt_load), .cnt_load_idx(cnt_load_idx), .cnt_load_byte(cnt_load_byte)
  );

  function automatic logic [7:0] pat(input int k, input int i);
    return 8'((k * 37 + i * 11 + 5) & 8'hFF);
  endfunction

  function automatic logic [7:0] fill(input int i);
    return 8'((i * 7 + 3) & 8'hFF);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic set_time(input int k);
    for (int i = 0; i < 8; i++) cnt_time[i*8 +: 8] = pat(k, i);
  endtask

  task automatic ld(input logic [4:0] a);
    addr_in = a; addr_load = 1'b1;
    @(negedge clk); addr_load = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v, input logic with_tick);
    rd_stb = 1'b1; cnt_tick = with_tick;
    @(negedge clk); rd_stb = 1'b0; cnt_tick = 1'b0;
    v = rd_data;
  endtask

  task automatic wr(input logic [7:0] d, input int idx);
    wr_data = d; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
    if (idx < 8) begin
      check("R9 load", {31'b0, cnt_load}, 32'd1);
      check("R9 idx", {29'b0, cnt_load_idx}, 32'(idx));
      check("R9 byte", {24'b0, cnt_load_byte}, {24'b0, d});
    end else begin
      check("R9 no load", {31'b0, cnt_load}, 32'd0);
    end
  endtask

  task automatic tick1();
    cnt_tick = 1'b1; @(negedge clk); cnt_tick = 1'b0;
  endtask

  task automatic stop1();
    bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 rd_data", {24'b0, rd_data}, 32'd0);
    check("R1 cnt_load", {31'b0, cnt_load}, 32'd0);
    for (int i = 0; i < 20; i++) begin
      rd(v, 1'b0);
      check("R1 byte", {24'b0, v}, 32'd0);
    end
    stop1();

    // R4/R9 write all bytes; pointer wraps 13h->00h (R3/R4 wrap)
    ld(5'd0);
    for (int i = 0; i < 20; i++) wr(fill(i), i);
    for (int i = 0; i < 20; i++) begin
      rd(v, 1'b0);
      check("R4 readback", {24'b0, v}, {24'b0, fill(i)});
    end
    stop1();

    // R2 pointer load to each address, single read; R3 capture
    for (int a = 0; a < 20; a++) begin
      ld(5'(a));
      rd(v, 1'b0);
      check("R2 load addr", {24'b0, v}, {24'b0, fill(a)});
      stop1();
    end
    ld(5'd25);
    rd(v, 1'b0);
    check("R2 out of range", {24'b0, v}, {24'b0, fill(0)});
    stop1();

    // R5 plain refresh
    set_time(1); tick1();
    ld(5'd0);
    for (int i = 0; i < 8; i++) begin
      rd(v, 1'b0);
      check("R5 refresh", {24'b0, v}, {24'b0, pat(1, i)});
    end
    rd(v, 1'b0);
    check("R5 plain byte kept", {24'b0, v}, {24'b0, fill(8)});
    stop1();

    // R6/R8 burst with ticks inside; pointer reaching 08h releases
    ld(5'd0);
    rd(v, 1'b0);
    check("R6 first", {24'b0, v}, {24'b0, pat(1, 0)});
    set_time(2); tick1();
    for (int i = 1; i < 4; i++) begin
      rd(v, 1'b0);
      check("R6 frozen", {24'b0, v}, {24'b0, pat(1, i)});
    end
    set_time(3); tick1();
    for (int i = 4; i < 8; i++) begin
      rd(v, 1'b0);
      check("R6 frozen", {24'b0, v}, {24'b0, pat(1, i)});
    end
    @(negedge clk);
    set_time(4);   // no tick: must not be picked up
    @(negedge clk);
    ld(5'd0);
    for (int i = 0; i < 8; i++) begin
      rd(v, 1'b0);
      check("R8 single latest replay", {24'b0, v}, {24'b0, pat(3, i)});
    end
    stop1();

    // R7 release by stop
    ld(5'd2);
    rd(v, 1'b0);
    check("R7 pre", {24'b0, v}, {24'b0, pat(3, 2)});
    set_time(5); tick1();
    rd(v, 1'b0);
    check("R7 held", {24'b0, v}, {24'b0, pat(3, 3)});
    stop1();
    @(negedge clk);
    ld(5'd0);
    for (int i = 0; i < 8; i++) begin
      rd(v, 1'b0);
      check("R7 after stop", {24'b0, v}, {24'b0, pat(5, i)});
    end
    stop1();

    // R7 release by pointer load into 08h..13h
    ld(5'd0);
    rd(v, 1'b0);
    set_time(6); tick1();
    ld(5'd12);
    @(negedge clk);
    ld(5'd1);
    rd(v, 1'b0);
    check("R7 after load to 0Ch", {24'b0, v}, {24'b0, pat(6, 1)});
    stop1();

    // R10 read at 13h wraps into clock range, no hold
    ld(5'd19);
    rd(v, 1'b0);
    check("R10 read 13h", {24'b0, v}, {24'b0, fill(19)});
    set_time(7); tick1();
    @(negedge clk);
    rd(v, 1'b0);
    check("R10 no hold after wrap", {24'b0, v}, {24'b0, pat(7, 0)});
    stop1();

    // R6 tick in the very cycle of the first clock read
    ld(5'd0);
    set_time(8);
    rd(v, 1'b1);
    check("R6 same-cycle first", {24'b0, v}, {24'b0, pat(7, 0)});
    rd(v, 1'b0);
    check("R6 same-cycle coherent", {24'b0, v}, {24'b0, pat(7, 1)});
    stop1();
    @(negedge clk);
    ld(5'd1);
    rd(v, 1'b0);
    check("R8 replay after same-cycle", {24'b0, v}, {24'b0, pat(8, 1)});
    stop1();

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule